// File: doc/BRIEF.md
# Flash Pulse Timer

This block times a single high pulse that drives a nonvolatile-memory program or erase operation. Software sets the pulse width through three fields: a 3-bit scale code that divides the system clock down to a slower memory clock, a 2-bit exponent code that picks a power-of-two count of memory-clock periods, and a 7-bit linear code that repeats that count from 1 to 128 times. An erase-select bit and a censor-select bit each raise the exponent by ten, which moves the pulse from the microsecond range into the millisecond range.

A start request is accepted only while the timer is idle. On the edge that accepts it, the timer captures every field, raises the pulse and the busy flag, and runs three cascaded counters: prescaler, exponential stage and linear stage. When the last stage wraps, the pulse and busy fall together and a done strobe is high for one system clock. The block has no data stream, so all of its pins are plain control and status levels with no handshake.

Top module: `flash_pulse_timer`

## Requirements
- R1: While reset is asserted, and after it is released until a start is accepted, `pulse`, `busy` and `done` are low.
- R2: An accepted pulse stays high for exactly D × 2^N × M system clock cycles, where D is the prescaler divider, N the exponent and M the linear multiplier, all taken from the captured fields.
- R3: The scale code maps to the divider as follows: codes 0, 1 and 2 give D = 1, and any code c of 3 or more gives D = c − 1, so code 5 gives D = 4 and code 7 gives D = 6.
- R4: The exponent is N = 5 + exponent code + 10 when `erase_sel` or `censor_sel` is high, and N = 5 + exponent code otherwise, giving 5..8 or 15..18.
- R5: The linear multiplier is M = 1 + linear code, so code 0 gives one pulse unit and code 127 gives 128 units, exactly 128 times the width of code 0.
- R6: A start seen high while idle is accepted on that clock edge, after which `pulse` and `busy` are both high; `busy` equals `pulse` on every cycle.
- R7: A start seen while busy is ignored: it neither shortens, lengthens nor restarts the current pulse, and no second pulse follows.
- R8: All fields are captured on the accepting edge; changing any field input while busy has no effect on the width of the running pulse.
- R9: On the edge that ends the pulse, `pulse` and `busy` fall and `done` rises; `done` is high for exactly one cycle.
- R10: The stage counters never run past their limits for any setting, up to 2^18 × 128 × 6 system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a pulse; accepted only while idle |
| scale_code | input | SCALE_W (3) | Prescaler code selecting the divider |
| exp_code | input | EXP_W (2) | Exponent code added to the base exponent |
| erase_sel | input | 1 | Erase operation; adds ten to the exponent |
| censor_sel | input | 1 | Censor operation; adds ten to the exponent |
| lin_code | input | LIN_W (7) | Linear multiplier minus one |
| pulse | output | 1 | Timed program/erase pulse |
| busy | output | 1 | High while a pulse is in progress |
| done | output | 1 | One-cycle strobe when the pulse ends |

## Verification
The assertions watch, on every cycle, that a start while idle raises pulse and busy on the next edge, that busy and pulse never differ, that the captured fields stay frozen while busy, that done is a single-cycle strobe coinciding with the fall of busy, and that the linear counter never passes its limit. The exact pulse width as a product of divider, power of two and linear multiplier, the divider chosen by each scale code, the ten-step exponent jump for erase and censor, and the ignored mid-pulse start and field changes can only be shown by the bench scenarios, which count the cycles the pulse is high against values computed from the requirements.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;

  // Exponent offset applied to every pulse and the extra step for erase/censor.
  localparam int unsigned EXP_BASE = 5;
  localparam int unsigned EXP_JUMP = 10;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } fpt_state_e;

  // Divider for a scale code: low codes pass the clock, higher ones divide by code-1.
  function automatic int unsigned scale_divider(int unsigned code);
    return (code < 3) ? 1 : code - 1;
  endfunction

  // Largest divider any code of the given width can select.
  function automatic int unsigned max_divider(int unsigned code_w);
    int unsigned m;
    m = 1;
    for (int unsigned c = 0; c < (32'd1 << code_w); c++) begin
      if (scale_divider(c) > m) m = scale_divider(c);
    end
    return m;
  endfunction

endpackage

// File: rtl/fpt_prescaler.sv
module fpt_prescaler
  import flash_pulse_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int unsigned DIV_MAX = max_divider(CODE_W);
  localparam int unsigned CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  generate
    if (DIV_MAX == 1) begin : g_bypass
      // Every code passes the clock straight through.
      assign tick = run;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] last;

      always_comb last = CNT_W'(scale_divider(32'(code)) - 1);

      assign tick = run && (cnt_q == last);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (clr) begin
          cnt_q <= '0;
        end else if (run) begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fpt_exp_stage.sv
module fpt_exp_stage #(
  parameter int unsigned EXP_MAX = 18,
  parameter int unsigned N_W     = $clog2(EXP_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_tick,
  input  logic [N_W-1:0] expo,
  output logic           out_tick
);

  logic [EXP_MAX-1:0] cnt_q;
  logic [EXP_MAX-1:0] term;

  // 2^expo - 1; wraps to all ones when expo equals the counter width.
  always_comb term = (EXP_MAX'(1) << expo) - 1'b1;

  assign out_tick = in_tick && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (in_tick) begin
      cnt_q <= out_tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fpt_lin_stage.sv
module fpt_lin_stage #(
  parameter int unsigned LIN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_tick,
  input  logic [LIN_W-1:0] lim,
  output logic [LIN_W-1:0] cnt,
  output logic             out_tick
);

  logic [LIN_W-1:0] cnt_q;

  assign out_tick = in_tick && (cnt_q == lim);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (in_tick) begin
      cnt_q <= out_tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer
  import flash_pulse_pkg::*;
#(
  parameter int unsigned SCALE_W = 3,
  parameter int unsigned EXP_W   = 2,
  parameter int unsigned LIN_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [EXP_W-1:0]   exp_code,
  input  logic               erase_sel,
  input  logic               censor_sel,
  input  logic [LIN_W-1:0]   lin_code,
  output logic               pulse,
  output logic               busy,
  output logic               done
);

  localparam int unsigned EXP_MAX = EXP_BASE + (2 ** EXP_W - 1) + EXP_JUMP;
  localparam int unsigned N_W     = $clog2(EXP_MAX + 1);

  fpt_state_e         state_q;
  logic               pulse_q;
  logic               done_q;
  logic [SCALE_W-1:0] scale_q;
  logic [EXP_W-1:0]   exp_q;
  logic               erase_q;
  logic               censor_q;
  logic [LIN_W-1:0]   lin_q;

  logic               accept;
  logic               running;
  logic               pre_tick;
  logic               exp_tick;
  logic               fin;
  logic [N_W-1:0]     expo;
  logic [LIN_W-1:0]   lin_cnt;

  assign running = (state_q == ST_PULSE);
  assign accept  = start && !running;

  always_comb begin
    expo = N_W'(EXP_BASE) + N_W'(exp_q);
    if (erase_q || censor_q) expo = expo + N_W'(EXP_JUMP);
  end

  // Field capture on the accepting edge; held for the whole pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q  <= '0;
      exp_q    <= '0;
      erase_q  <= 1'b0;
      censor_q <= 1'b0;
      lin_q    <= '0;
    end else if (accept) begin
      scale_q  <= scale_code;
      exp_q    <= exp_code;
      erase_q  <= erase_sel;
      censor_q <= censor_sel;
      lin_q    <= lin_code;
    end
  end

  // Control state, pulse and done strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PULSE;
            pulse_q <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (fin) begin
            state_q <= ST_IDLE;
            pulse_q <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fpt_prescaler #(
    .CODE_W (SCALE_W)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .run   (running),
    .code  (scale_q),
    .tick  (pre_tick)
  );

  fpt_exp_stage #(
    .EXP_MAX (EXP_MAX),
    .N_W     (N_W)
  ) u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .in_tick  (pre_tick),
    .expo     (expo),
    .out_tick (exp_tick)
  );

  fpt_lin_stage #(
    .LIN_W (LIN_W)
  ) u_lin (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .in_tick  (exp_tick),
    .lim      (lin_q),
    .cnt      (lin_cnt),
    .out_tick (fin)
  );

  assign pulse = pulse_q;
  assign busy  = running;
  assign done  = done_q;

endmodule

// File: rtl/fpt_checker.sv
module fpt_checker #(
  parameter int unsigned SCALE_W = 3,
  parameter int unsigned EXP_W   = 2,
  parameter int unsigned LIN_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               pulse,
  input logic               busy,
  input logic               done,
  input logic               fin,
  input logic [SCALE_W-1:0] scale_q,
  input logic [EXP_W-1:0]   exp_q,
  input logic               erase_q,
  input logic               censor_q,
  input logic [LIN_W-1:0]   lin_q,
  input logic [LIN_W-1:0]   lin_cnt
);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!pulse && !busy && !done)
        else $error("outputs active during reset");
    end
  end

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && pulse));

  p_pulse_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy == pulse);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !fin) |=> busy);

  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({scale_q, exp_q, erase_q, censor_q, lin_q}));

  p_done_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lin_cnt <= lin_q));

endmodule

bind flash_pulse_timer fpt_checker #(
  .SCALE_W (SCALE_W),
  .EXP_W   (EXP_W),
  .LIN_W   (LIN_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .pulse    (pulse),
  .busy     (busy),
  .done     (done),
  .fin      (fin),
  .scale_q  (scale_q),
  .exp_q    (exp_q),
  .erase_q  (erase_q),
  .censor_q (censor_q),
  .lin_q    (lin_q),
  .lin_cnt  (lin_cnt)
);

// File: tb/test_flash_pulse_timer.sv
`timescale 1ns/1ps
module test_flash_pulse_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] scale_code = '0;
  logic [1:0] exp_code = '0;
  logic       erase_sel = 1'b0;
  logic       censor_sel = 1'b0;
  logic [6:0] lin_code = '0;
  logic       pulse, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_pulse_timer i_flash_pulse_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .scale_code(scale_code), .exp_code(exp_code),
    .erase_sel(erase_sel), .censor_sel(censor_sel), .lin_code(lin_code),
    .pulse(pulse), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_width(int sc, int ec, bit er, bit cs, int lc);
    longint d = (sc < 3) ? 1 : sc - 1;
    int n = 5 + ec + ((er || cs) ? 10 : 0);
    return d * (longint'(1) << n) * (lc + 1);
  endfunction

  // Runs one pulse; with disturb set, fields change and start is pulsed mid-pulse.
  task automatic run_pulse(input string req, input int sc, input int ec, input bit er,
                           input bit cs, input int lc, input bit disturb);
    longint width = 0;
    longint want = expect_width(sc, ec, er, cs, lc);
    @(negedge clk);
    scale_code = 3'(sc); exp_code = 2'(ec); erase_sel = er; censor_sel = cs; lin_code = 7'(lc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6", "pulse high after accept", longint'(pulse && busy), 1);
    while (pulse && width < 400000) begin
      width++;
      if (disturb && width == 5) begin
        scale_code = 3'd7; exp_code = 2'd3; lin_code = 7'd100; erase_sel = 1'b1;
        start = 1'b1;
      end
      if (disturb && width == 6) start = 1'b0;
      if (busy != pulse) check("R6", "busy tracks pulse", longint'(busy), longint'(pulse));
      @(negedge clk);
    end
    check(req, "pulse width", width, want);
    check("R9", "done at fall", longint'(done && !busy), 1);
    @(negedge clk);
    check("R9", "done one cycle", longint'(done), 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      check("R7", "no second pulse", longint'(pulse || busy), 0);
      erase_sel = 1'b0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", longint'({pulse, busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "outputs idle after reset", longint'({pulse, busy, done}), 0);
  endtask

  task automatic t_prescaler();
    run_pulse("R3", 5, 0, 0, 0, 0, 0);   // divider 4 -> 128
    run_pulse("R3", 0, 0, 0, 0, 0, 0);   // divider 1 -> 32
    run_pulse("R3", 1, 0, 0, 0, 0, 0);
    run_pulse("R3", 3, 0, 0, 0, 0, 0);   // divider 2 -> 64
    run_pulse("R3", 7, 0, 0, 0, 0, 0);   // divider 6 -> 192
  endtask

  task automatic t_exponent();
    run_pulse("R4", 5, 3, 0, 0, 0, 0);   // 256 memory periods -> 1024
    run_pulse("R4", 0, 0, 1, 0, 0, 0);   // erase -> 2^15
    run_pulse("R4", 0, 0, 0, 1, 0, 0);   // censor -> 2^15
  endtask

  task automatic t_linear();
    run_pulse("R5", 5, 3, 0, 0, 2, 0);   // x3
    run_pulse("R5", 0, 0, 0, 0, 127, 0); // x128
    run_pulse("R2", 3, 1, 0, 0, 4, 0);   // 2*64*5
  endtask

  task automatic t_disturb();
    run_pulse("R8", 5, 1, 0, 0, 1, 1);   // 4*64*2, fields and start changed mid-pulse
  endtask

  initial begin
    t_reset();
    t_prescaler();
    t_exponent();
    t_linear();
    t_disturb();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule